// File: doc/BRIEF.md
# DRAM Page Hit Detector

This block sits beside an external memory bus interface and decides, for every external access, whether the address stays within the DRAM page opened by the previous access to the same memory space. A downstream DRAM timing generator reads the single output flag to choose between a fast page-mode or static-column cycle (hit) and a full row cycle (miss). Three memory spaces are tracked: program, X data and Y data. Each space has its own enable bit, its own latched row and its own page-valid flag.

The enable bits live in a small register inside the block. The register is loaded from `cfg_en` when `cfg_load` is high and is cleared by reset. Accesses arrive on a plain strobe, `acc_valid`. The block has no ready signal and applies no back-pressure: every strobe is evaluated in the cycle it is sampled. The result appears on `page_hit` after the next rising clock edge and is held for exactly one cycle. Tracking runs only while `bus_owner` is high. Whenever the device is not bus owner, every open page is forgotten.

Top module: `dram_page_hit_det`

## Requirements
- R1: Reset drives `page_hit` low, clears all three enable bits and marks every space as having no open page.
- R2: Space codes on `acc_space` are 2'b10 program, 2'b01 X data and 2'b00 Y data. The enable for code k is `cfg_en[k]`, so bit 2 is program, bit 1 is X and bit 0 is Y. The enables take effect from the cycle after `cfg_load` is sampled high.
- R3: An access with space code 2'b11 is never monitored. It leaves `page_hit` low and changes no open page.
- R4: An access to a space whose enable bit is clear leaves `page_hit` low and does not change that space's open page or its valid flag.
- R5: A monitored access (strobe, bus owner and enable all high) whose row equals the open row of a valid page in its space drives `page_hit` high in the cycle after the strobe is sampled.
- R6: A monitored access whose row differs from the open row drives `page_hit` low (a page fault). The access's row becomes that space's open row, so a following access to the same row hits.
- R7: The first monitored access to a space after reset or after loss of bus ownership is always a fault.
- R8: While `bus_owner` is low, accesses are not monitored, `page_hit` is low in the following cycle, and all three spaces lose their open page.
- R9: `page_hit` is low in any cycle that follows a cycle in which `acc_valid` was low.
- R10: Each space keeps its own open row. An access to one space never changes the hit or fault result of another space.
- R11: The row is `acc_addr[ADDR_W-1:COL_W]`. The low `COL_W` column bits never affect the hit decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Load strobe for the enable register |
| cfg_en | input | 3 | New enable bits: [2] program, [1] X, [0] Y |
| bus_owner | input | 1 | High while this device owns the external bus |
| acc_valid | input | 1 | External access strobe from the CPU or DMA engine |
| acc_space | input | 2 | Memory space code of the access |
| acc_addr | input | ADDR_W | Access address |
| page_hit | output | 1 | Registered transfer-type flag: access stayed in the open page |

## Verification
A corrupted open row or valid flag only shows up at the port on the next access to the same space. A stale row turns an expected hit into a fault, or the reverse, one cycle after that strobe. For this reason the bench follows each disturbance (a disabled access, a code 11 access, an access to another space, a loss of bus ownership) with a probing access to the row that should still be open or should now be invalid. A wrong enable register shows on the first access after the load. A stuck output shows in any idle cycle.

// File: rtl/dph_pkg.sv
package dph_pkg;
  localparam int NUM_SPACES = 3;

  typedef enum logic [1:0] {
    SP_YDATA = 2'b00,
    SP_XDATA = 2'b01,
    SP_PROG  = 2'b10,
    SP_NONE  = 2'b11
  } space_e;
endpackage

// File: rtl/dph_space_decode.sv
module dph_space_decode
  import dph_pkg::*;
#(
  parameter int N = NUM_SPACES
) (
  input  logic         acc_valid,
  input  logic         bus_owner,
  input  logic [1:0]   acc_space,
  input  logic [N-1:0] en,
  output logic [N-1:0] mon
);
  // One monitor line per space; code 11 matches no index and stays idle.
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign mon[i] = acc_valid & bus_owner & en[i] & (acc_space == 2'(i));
  end
endmodule

// File: rtl/dph_page_tracker.sv
module dph_page_tracker #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             mon,
  input  logic [ROW_W-1:0] row,
  output logic             hit_now
);
  logic [ROW_W-1:0] open_row_q;
  logic             open_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row_q <= '0;
      open_vld_q <= 1'b0;
    end else if (flush) begin
      open_vld_q <= 1'b0;
    end else if (mon) begin
      open_row_q <= row;
      open_vld_q <= 1'b1;
    end
  end

  assign hit_now = open_vld_q && (open_row_q == row);

  // R7: after a flush no page is open
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !open_vld_q);
  // R6: every monitored access opens its own row
  p_mon_opens_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mon && !flush) |=> (open_vld_q && open_row_q == $past(row)));
  // R4: an unmonitored cycle keeps the row
  p_row_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mon |=> $stable(open_row_q));
endmodule

// File: rtl/dram_page_hit_det.sv
module dram_page_hit_det
  import dph_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [2:0]        cfg_en,
  input  logic              bus_owner,
  input  logic              acc_valid,
  input  logic [1:0]        acc_space,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              page_hit
);
  localparam int ROW_W = ADDR_W - COL_W;

  logic [NUM_SPACES-1:0] en_q;
  logic [NUM_SPACES-1:0] mon;
  logic [NUM_SPACES-1:0] hit_vec;
  logic [ROW_W-1:0]      acc_row;
  logic                  unused_col;
  logic                  page_hit_q;

  assign acc_row    = acc_addr[ADDR_W-1:COL_W];
  assign unused_col = ^acc_addr[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (cfg_load) en_q <= cfg_en;
  end

  dph_space_decode #(.N(NUM_SPACES)) u_dec (
    .acc_valid (acc_valid),
    .bus_owner (bus_owner),
    .acc_space (acc_space),
    .en        (en_q),
    .mon       (mon)
  );

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_trk
    dph_page_tracker #(.ROW_W(ROW_W)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (!bus_owner),
      .mon     (mon[s]),
      .row     (acc_row),
      .hit_now (hit_vec[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_hit_q <= 1'b0;
    else        page_hit_q <= |(mon & hit_vec);
  end

  assign page_hit = page_hit_q;

  // R9: no strobe, no hit next cycle
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !page_hit);
  // R8: not bus owner, no hit next cycle
  p_not_owner_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_owner |=> !page_hit);
  // R3: code 11 is never monitored
  p_code11_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_space == SP_NONE) |=> !page_hit);
  // R4: a disabled space cannot produce a hit
  p_disabled_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_space != SP_NONE && !en_q[acc_space]) |=> !page_hit);
  // R2: enables follow the load
  p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (en_q == $past(cfg_en)));
endmodule

// File: tb/tb_dram_page_hit_det.sv
module tb_dram_page_hit_det;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int COL_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_load = 1'b0;
  logic [2:0]        cfg_en = '0;
  logic              bus_owner = 1'b0;
  logic              acc_valid = 1'b0;
  logic [1:0]        acc_space = '0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              page_hit;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_page_hit_det #(.ADDR_W(ADDR_W), .COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_en(cfg_en),
    .bus_owner(bus_owner), .acc_valid(acc_valid), .acc_space(acc_space),
    .acc_addr(acc_addr), .page_hit(page_hit)
  );

  localparam logic [1:0] SY = 2'b00, SX = 2'b01, SP = 2'b10, SN = 2'b11;

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: page_hit=%b expected=%b", tag, got, exp);
    end
  endtask

  // Drive one access on a falling edge; result is read at the next falling edge.
  task automatic acc(input logic [1:0] sp, input logic [ADDR_W-1:0] a,
                     input string tag, input logic exp);
    acc_valid = 1'b1; acc_space = sp; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    check(tag, page_hit, exp);
  endtask

  task automatic load_en(input logic [2:0] e);
    cfg_load = 1'b1; cfg_en = e;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset output", page_hit, 1'b0);
    rst_n = 1'b1; bus_owner = 1'b1;
    @(negedge clk);
    acc(SX, 16'h1200, "R1 enables clear after reset", 1'b0);
    acc(SX, 16'h1200, "R1 enables still clear", 1'b0);
  endtask

  task automatic t_basic;
    load_en(3'b111);
    acc(SX, 16'h3400, "R7 first access faults", 1'b0);
    acc(SX, 16'h3455, "R5 same row hits", 1'b1);
    acc(SX, 16'h3500, "R6 new row faults", 1'b0);
    acc(SX, 16'h35FF, "R6 new row now open", 1'b1);
    acc(SX, 16'h3501, "R11 column bits ignored", 1'b1);
  endtask

  task automatic t_idle;
    acc(SX, 16'h3502, "R5 hit before idle", 1'b1);
    @(negedge clk);
    check("R9 idle cycle low", page_hit, 1'b0);
  endtask

  task automatic t_code11;
    acc(SN, 16'h3500, "R3 code 11 low", 1'b0);
    acc(SN, 16'h7700, "R3 code 11 other row", 1'b0);
    acc(SX, 16'h3510, "R3 X page untouched", 1'b1);
  endtask

  task automatic t_spaces;
    acc(SP, 16'hA000, "R2 program first fault", 1'b0);
    acc(SP, 16'hA0AA, "R2 program code 10 hits", 1'b1);
    acc(SY, 16'hB000, "R2 Y first fault", 1'b0);
    acc(SY, 16'hB0CC, "R2 Y code 00 hits", 1'b1);
    acc(SX, 16'h3520, "R10 X unaffected by others", 1'b1);
    acc(SP, 16'hA001, "R10 program unaffected", 1'b1);
  endtask

  task automatic t_disabled;
    load_en(3'b101);
    acc(SX, 16'h3530, "R4 disabled X low", 1'b0);
    acc(SX, 16'h9900, "R4 disabled X other row", 1'b0);
    acc(SP, 16'hA002, "R2 program enable bit2", 1'b1);
    load_en(3'b111);
    acc(SX, 16'h3540, "R4 X row kept while disabled", 1'b1);
    load_en(3'b011);
    acc(SP, 16'hA003, "R2 program disabled by bit2", 1'b0);
    acc(SY, 16'hB001, "R2 Y enabled by bit0", 1'b1);
    load_en(3'b111);
  endtask

  task automatic t_owner;
    bus_owner = 1'b0;
    acc(SX, 16'h3550, "R8 not owner low", 1'b0);
    bus_owner = 1'b1;
    acc(SX, 16'h3550, "R7 X fault after ownership loss", 1'b0);
    acc(SY, 16'hB002, "R8 Y page lost", 1'b0);
    acc(SP, 16'hA004, "R8 program page lost", 1'b0);
    acc(SX, 16'h3560, "R6 X reopened", 1'b1);
  endtask

  task automatic t_reset_again;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run output", page_hit, 1'b0);
    rst_n = 1'b1;
    load_en(3'b111);
    acc(SX, 16'h3560, "R7 first access after reset faults", 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: page_hit=%b expected=finish", page_hit);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_idle();
    t_code11();
    t_spaces();
    t_disabled();
    t_owner();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule